// File: doc/BRIEF.md
# Peripheral Event Routing Matrix

This block lets peripherals signal one another with single-cycle pulses, with no processor in the path. Each generator peripheral drives one bit of `gen_evt`. Every event channel keeps a mask that picks which generators feed it. All generators picked by one channel are OR-combined. Every user input chooses one channel, or none, and any number of users may choose the same channel. After software has written the routing, pulses move from generators to users with no further action.

Each channel runs in one of two modes. In the registered mode, an event passes through one register in the channel and one register in each user path, so it arrives exactly two cycles after the generator pulse. In the pass-through mode, the event reaches the users in the same cycle, through logic only. Software can also inject one pulse on any channel through a trigger register. The injected pulse joins that channel's generator pulses.

Configuration uses a simple write port: enable, address and data. A write changes the routing from the next cycle onward. An event already inside the registered path keeps the route it was given when it entered.

Top module: `event_route_matrix`

## Requirements
- R1: Address c, for c below NUM_CH, holds the generator mask of channel c in data bits [NUM_GEN-1:0]. Generator g reaches channel c only while mask bit g of channel c is set.
- R2: When two or more masked generators on one channel pulse in the same cycle, each connected user sees a single one-cycle pulse. When they pulse in different cycles, each connected user sees one pulse per cycle.
- R3: Every user whose select names the same channel sees exactly the same pulses in the same cycles.
- R4: On a channel in registered mode, a generator pulse in cycle n appears on connected users in cycle n+2 and in no other cycle.
- R5: On a channel in pass-through mode, a generator pulse appears on connected users in the same cycle.
- R6: Address NUM_CH+2+u holds the select of user u in data bits [SELW-1:0]. Value c+1 connects the user to channel c. Value 0, or any value above NUM_CH, disconnects the user, whose output then stays low.
- R7: A write takes effect in the cycle after it. For an event entering a registered channel in cycle n, the channel mask and mode in force in cycle n apply, and the user select in force in cycle n+1 applies. Later writes do not change where or whether that event is delivered.
- R8: A write to address NUM_CH+1 with data bit c set injects exactly one pulse on channel c, in the cycle after the write. The pulse is then delivered like a generator pulse.
- R9: Address NUM_CH holds the mode bits in data bits [NUM_CH-1:0]. Bit c = 1 puts channel c in pass-through mode, and bit c = 0 puts it in registered mode.
- R10: After reset all masks are zero, all channels are in registered mode, no trigger is pending, all selects are zero, and every user output is low.
- R11: A write to an address at or above NUM_CH+2+NUM_USR changes no routing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, and must be released in step with clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register address |
| cfg_wdata | input | CFG_DW | Configuration write data |
| gen_evt | input | NUM_GEN | One pulse bit per generator peripheral |
| user_evt | output | NUM_USR | One pulse bit per user input |

## Verification
The assertions assume that `rst_n` is released in step with the clock. They also assume that `cfg_wdata` and `gen_evt` are stable around each rising edge, so each pulse the block receives lasts exactly one cycle. The bench changes every input one time unit after a rising edge and holds it for the whole cycle. This meets the stability assumption, including in the random phase. During that phase, writes to any address share cycles with sparse generator bursts. The bench model follows the pipeline timing given in R4 and R7. For that reason, writes can fall in the middle of a registered event without creating an ambiguous expected value.

// File: rtl/evr_pkg.sv
package evr_pkg;

  // Decoded kind of a configuration address
  typedef enum logic [2:0] {
    RK_NONE,
    RK_MASK,
    RK_PASS,
    RK_TRIG,
    RK_SEL
  } reg_kind_e;

  function automatic int addr_pass(input int nch);
    return nch;
  endfunction

  function automatic int addr_trig(input int nch);
    return nch + 1;
  endfunction

  function automatic int addr_sel0(input int nch);
    return nch + 2;
  endfunction

endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs
  import evr_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_CH  = 4,
  parameter int NUM_USR = 6,
  parameter int SELW    = 3,
  parameter int CFG_AW  = 4,
  parameter int CFG_DW  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [CFG_DW-1:0]                cfg_wdata,
  output logic [NUM_CH-1:0][NUM_GEN-1:0]   mask_o,
  output logic [NUM_CH-1:0]                pass_o,
  output logic [NUM_CH-1:0]                trig_o,
  output logic [NUM_USR-1:0][SELW-1:0]     sel_o
);

  localparam int A_PASS = addr_pass(NUM_CH);
  localparam int A_TRIG = addr_trig(NUM_CH);
  localparam int A_SEL0 = addr_sel0(NUM_CH);
  localparam int A_END  = A_SEL0 + NUM_USR;

  logic [NUM_CH-1:0][NUM_GEN-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0]              pass_q, pass_d;
  logic [NUM_CH-1:0]              trig_q, trig_d;
  logic [NUM_USR-1:0][SELW-1:0]   sel_q, sel_d;
  logic [31:0]                    a32;
  reg_kind_e                      kind;
  logic                           cfg_en;

  // Address decode
  always_comb begin
    a32 = 32'(cfg_addr);
    if (a32 < NUM_CH)        kind = RK_MASK;
    else if (a32 == A_PASS)  kind = RK_PASS;
    else if (a32 == A_TRIG)  kind = RK_TRIG;
    else if (a32 < A_END)    kind = RK_SEL;
    else                     kind = RK_NONE;
  end

  // Clock enable of the held routing state
  assign cfg_en = cfg_we && (kind == RK_MASK || kind == RK_PASS || kind == RK_SEL);

  // Next state
  always_comb begin
    mask_d = mask_q;
    pass_d = pass_q;
    sel_d  = sel_q;
    trig_d = '0;
    if (cfg_we) begin
      case (kind)
        RK_MASK: for (int c = 0; c < NUM_CH; c++)
                   if (a32 == c) mask_d[c] = cfg_wdata[NUM_GEN-1:0];
        RK_PASS: pass_d = cfg_wdata[NUM_CH-1:0];
        RK_TRIG: trig_d = cfg_wdata[NUM_CH-1:0];
        RK_SEL:  for (int u = 0; u < NUM_USR; u++)
                   if (a32 == A_SEL0 + u) sel_d[u] = cfg_wdata[SELW-1:0];
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pass_q <= '0;
      sel_q  <= '0;
      trig_q <= '0;
    end else begin
      trig_q <= trig_d;
      if (cfg_en) begin
        mask_q <= mask_d;
        pass_q <= pass_d;
        sel_q  <= sel_d;
      end
    end
  end

  assign mask_o = mask_q;
  assign pass_o = pass_q;
  assign trig_o = trig_q;
  assign sel_o  = sel_q;

  // R8: an injected pulse lasts one cycle unless rewritten
  a_r8_trig_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q != '0 && !(cfg_we && kind == RK_TRIG)) |=> (trig_q == '0));

  // R11: unmapped writes leave routing untouched
  a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && kind == RK_NONE) |=> ($stable(mask_q) && $stable(pass_q) && $stable(sel_q)));

  // R7 / R9: a mode write is visible in the following cycle
  a_r9_mode_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && kind == RK_PASS) |=> (pass_q == $past(cfg_wdata[NUM_CH-1:0])));

endmodule

// File: rtl/evr_channel.sv
module evr_channel #(
  parameter int NUM_GEN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GEN-1:0] gen_evt,
  input  logic [NUM_GEN-1:0] mask,
  input  logic               pass,
  input  logic               trig,
  output logic               raw_o,
  output logic               sync_o
);

  logic sync_q, sync_d, sync_en;

  // OR of every masked generator plus the software pulse
  assign raw_o = (|(gen_evt & mask)) | trig;

  // The input register stage is used only in registered mode
  assign sync_en = 1'b1;
  assign sync_d  = raw_o & ~pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sync_q <= 1'b0;
    else if (sync_en) sync_q <= sync_d;
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/evr_user_mux.sv
module evr_user_mux #(
  parameter int NUM_CH = 4,
  parameter int SELW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SELW-1:0]   sel,
  input  logic [NUM_CH-1:0] ch_raw,
  input  logic [NUM_CH-1:0] ch_pass,
  input  logic [NUM_CH-1:0] ch_sync,
  output logic              evt_o
);

  logic hit_raw, hit_pass, hit_sync;
  logic out_q, out_d;

  // Select decode: value c+1 picks channel c, every other value picks nothing
  always_comb begin
    hit_raw  = 1'b0;
    hit_pass = 1'b0;
    hit_sync = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel == SELW'(c + 1)) begin
        hit_raw  = ch_raw[c];
        hit_pass = ch_pass[c];
        hit_sync = ch_sync[c];
      end
    end
  end

  // Output register stage of the registered path
  assign out_d = hit_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign evt_o = out_q | (hit_pass & hit_raw);

  // R6: a disconnected user stays silent
  a_r6_disconnected_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == '0 || sel > NUM_CH) && ($past(sel) == '0 || $past(sel) > NUM_CH)) |-> !evt_o);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5: pass-through event seen in the same cycle
    a_r5_pass_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SELW'(c + 1) && ch_pass[c] && ch_raw[c]) |-> evt_o);
    // R4: a registered channel event reaches the user on the next edge
    a_r4_sync_delivered: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SELW'(c + 1) && $past(sel) == sel && $past(ch_sync[c])) |-> evt_o);
  end

endmodule

// File: rtl/event_route_matrix.sv
module event_route_matrix #(
  parameter int NUM_GEN = 8,
  parameter int NUM_CH  = 4,
  parameter int NUM_USR = 6,
  parameter int CFG_AW  = 4,
  parameter int CFG_DW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic [NUM_GEN-1:0] gen_evt,
  output logic [NUM_USR-1:0] user_evt
);

  localparam int SELW = $clog2(NUM_CH + 1);

  logic [NUM_CH-1:0][NUM_GEN-1:0] mask;
  logic [NUM_CH-1:0]              pass, trig, ch_raw, ch_sync;
  logic [NUM_USR-1:0][SELW-1:0]   sel;

  evr_cfg_regs #(
    .NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH), .NUM_USR(NUM_USR),
    .SELW(SELW), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mask_o(mask), .pass_o(pass), .trig_o(trig), .sel_o(sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evr_channel #(.NUM_GEN(NUM_GEN)) ch_i (
      .clk(clk), .rst_n(rst_n),
      .gen_evt(gen_evt), .mask(mask[c]), .pass(pass[c]), .trig(trig[c]),
      .raw_o(ch_raw[c]), .sync_o(ch_sync[c])
    );
  end

  for (genvar u = 0; u < NUM_USR; u++) begin : g_usr
    evr_user_mux #(.NUM_CH(NUM_CH), .SELW(SELW)) usr_i (
      .clk(clk), .rst_n(rst_n),
      .sel(sel[u]), .ch_raw(ch_raw), .ch_pass(pass), .ch_sync(ch_sync),
      .evt_o(user_evt[u])
    );
  end

  // R3: users on one channel, unchanged for two cycles, agree
  for (genvar u = 1; u < NUM_USR; u++) begin : g_fan
    a_r3_fanout_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[u] == sel[0] && sel[0] != '0 && $past(sel[u]) == sel[u] && $past(sel[0]) == sel[0])
      |-> (user_evt[u] == user_evt[0]));
  end

endmodule

// File: tb/event_route_matrix_tb.sv
module event_route_matrix_tb_top;

  localparam int CLK_P = 10;
  localparam int NG = 8;
  localparam int NC = 4;
  localparam int NU = 6;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int A_PASS = NC;
  localparam int A_TRIG = NC + 1;
  localparam int A_SEL0 = NC + 2;
  localparam int A_END  = NC + 2 + NU;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic [NG-1:0] gen_evt;
  logic [NU-1:0] user_evt;

  event_route_matrix #(
    .NUM_GEN(NG), .NUM_CH(NC), .NUM_USR(NU), .CFG_AW(AW), .CFG_DW(DW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gen_evt(gen_evt), .user_evt(user_evt)
  );

  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference state
  logic [NG-1:0] m_mask [NC];
  logic [NC-1:0] m_pass, m_trig, m_s1;
  int            m_sel  [NU];
  logic [NU-1:0] m_out;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_req = "R10";

  function automatic bit raw_of(input int c);
    return ((gen_evt & m_mask[c]) != '0) || m_trig[c];
  endfunction

  // Model update on each edge, from values in force before the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) m_mask[c] = '0;
      for (int u = 0; u < NU; u++) m_sel[u] = 0;
      m_pass = '0; m_trig = '0; m_s1 = '0; m_out = '0;
    end else begin
      logic [NC-1:0] s1_n;
      logic [NU-1:0] out_n;
      for (int c = 0; c < NC; c++) s1_n[c] = raw_of(c) && !m_pass[c];
      for (int u = 0; u < NU; u++)
        out_n[u] = (m_sel[u] >= 1 && m_sel[u] <= NC) ? m_s1[m_sel[u]-1] : 1'b0;
      m_s1  = s1_n;
      m_out = out_n;
      m_trig = '0;
      if (cfg_we) begin
        int a;
        a = int'(cfg_addr);
        if (a < NC)            m_mask[a] = cfg_wdata[NG-1:0];
        else if (a == A_PASS)  m_pass = cfg_wdata[NC-1:0];
        else if (a == A_TRIG)  m_trig = cfg_wdata[NC-1:0];
        else if (a < A_END)    m_sel[a-A_SEL0] = int'(cfg_wdata[2:0]);
      end
    end
  end

  // Compare at mid-cycle
  always @(negedge clk) begin
    if (!done) begin
      logic [NU-1:0] exp_v;
      for (int u = 0; u < NU; u++) begin
        exp_v[u] = m_out[u];
        if (m_sel[u] >= 1 && m_sel[u] <= NC)
          if (m_pass[m_sel[u]-1] && raw_of(m_sel[u]-1)) exp_v[u] = 1'b1;
      end
      n_chk++;
      if (user_evt !== exp_v) begin
        n_fail++;
        $display("FAIL %s: user_evt actual %b expected %b at %0t", cur_req, user_evt, exp_v, $time);
      end
    end
  end

  task automatic step(input logic we, input int a, input int d, input logic [NG-1:0] g);
    @(posedge clk); #1;
    cfg_we = we; cfg_addr = AW'(a); cfg_wdata = DW'(d); gen_evt = g;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, '0);
  endtask

  task automatic wr(input int a, input int d);
    step(1'b1, a, d, '0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL %s: watchdog expired, actual running expected finished", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; gen_evt = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state, generators active but nothing routed
    cur_req = "R10";
    step(1'b0, 0, 0, 8'hFF); step(1'b0, 0, 0, 8'h5A); idle(3);

    // R1: mask of channel 0 selects generator 2 only; user0 on channel 0
    cur_req = "R1";
    wr(0, 8'h04); wr(A_SEL0 + 0, 1);
    step(1'b0, 0, 0, 8'h04); idle(3);
    step(1'b0, 0, 0, 8'h08); idle(3);
    step(1'b0, 0, 0, 8'hFB); idle(3);

    // R6: disconnected and out-of-range selects; user2 on channel 1
    cur_req = "R6";
    wr(1, 8'h20); wr(A_SEL0 + 2, 2); wr(A_SEL0 + 1, 0); wr(A_SEL0 + 5, 7);
    step(1'b0, 0, 0, 8'h20); idle(3);
    step(1'b0, 0, 0, 8'h24); idle(3);

    // R2: two generators OR-combined on channel 0
    cur_req = "R2";
    wr(0, 8'h0C);
    step(1'b0, 0, 0, 8'h0C); idle(3);
    step(1'b0, 0, 0, 8'h04); step(1'b0, 0, 0, 8'h08); idle(3);

    // R3: fan-out of channel 0 to users 0, 3 and 4
    cur_req = "R3";
    wr(A_SEL0 + 3, 1); wr(A_SEL0 + 4, 1);
    step(1'b0, 0, 0, 8'h04); idle(1); step(1'b0, 0, 0, 8'h08); idle(3);

    // R4: registered latency with back-to-back pulses
    cur_req = "R4";
    step(1'b0, 0, 0, 8'h04); step(1'b0, 0, 0, 8'h04); step(1'b0, 0, 0, 8'h00);
    step(1'b0, 0, 0, 8'h08); idle(4);

    // R9 / R5: channel 0 pass-through, channel 1 stays registered
    cur_req = "R9";
    wr(A_PASS, 8'h01);
    step(1'b0, 0, 0, 8'h24); idle(3);
    cur_req = "R5";
    step(1'b0, 0, 0, 8'h04); step(1'b0, 0, 0, 8'h08); idle(2);

    // R7: change mask, mode and select while a registered event is in flight
    cur_req = "R7";
    wr(A_PASS, 8'h00); idle(1);
    step(1'b0, 0, 0, 8'h04); wr(0, 8'h00); wr(A_PASS, 8'h01); idle(3);
    wr(A_PASS, 8'h00); wr(0, 8'h04);
    step(1'b1, A_SEL0 + 0, 2, 8'h04); idle(3);
    step(1'b0, 0, 0, 8'h04); wr(A_SEL0 + 3, 0); idle(3);

    // R8: software trigger on channels 0 and 1
    cur_req = "R8";
    wr(A_TRIG, 8'h03); idle(4);
    wr(A_PASS, 8'h02); wr(A_TRIG, 8'h02); idle(3);
    step(1'b1, A_TRIG, 8'h01, 8'h04); idle(4);

    // R11: unmapped addresses leave routing unchanged
    cur_req = "R11";
    wr(A_END, 8'hFF); wr(15, 8'hFF);
    step(1'b0, 0, 0, 8'hFF); idle(3);

    // Random phase mixing writes and generator bursts
    cur_req = "R7";
    for (int i = 0; i < 400; i++) begin
      logic we;
      int a;
      we = ($urandom % 4) == 0;
      a  = $urandom % 16;
      step(we, a, $urandom % 256, NG'($urandom & $urandom & $urandom));
    end
    idle(4);

    done = 1;
    summary();
    $finish;
  end

endmodule